// File: doc/BRIEF.md
# Host Access Port for a Time-Slot Switch

This block is the byte-wide slave that lets a host processor program a time-slot switch. The host drives an asynchronous bus made of an active-low select, an active-high strobe, a read/write line (high for read), six address bits and eight data bits. The block answers with an active-low acknowledge that behaves like an open-drain pull-down. Inside the block is one 8-bit control byte. It holds a stream number, a memory selector, a split-access flag and a global message flag, and it turns the small address window into accesses to three per-stream, per-channel memories. These memories belong to the switch core: the received-sample store, the route/message byte store and the per-channel flag store.

The switch core runs a fixed per-channel schedule and grants one host slot in that schedule through `slot_open`. The block waits for that slot before it issues a single memory request. For a read, it picks up the returned byte in the cycle after the slot and only then lowers the acknowledge. A write to the control byte completes without waiting for any slot. The block drives the global message flag to the core on `msg_all`.

Top module: `hpa_top`

## Requirements
- R1: After reset the control byte is 0x00, `ack_n` is 1, `rdata_oe` is 0, `mem_req` is 0 and `msg_all` is 0.
- R2: Any access with `addr[5]`=0 reaches the control byte, whatever `addr[4:0]` holds. Control bit 5 holds nothing and reads back as 0.
- R3: A control-byte write is acknowledged (`ack_n` low) within 4 clock cycles of select and strobe becoming active, and it does not wait for `slot_open`.
- R4: With `addr[5]`=1 and split off, the memory is chosen by control bits 4:3 (01 sample store, 10 route store, 11 flag store). The address is `{control[2:0], addr[4:0]}` and the read returns the stored byte.
- R5: Each memory access makes exactly one `mem_req`, and it makes it only in a cycle where `slot_open` is 1. The acknowledge follows that cycle.
- R6: With control bit 7 set, memory reads go to the sample store (`mem_sel`=01) and memory writes go to the route store (`mem_sel`=10), whatever bits 4:3 hold.
- R7: A flag-store access keeps only bits 2:0. Written bits 7:3 are sent as 0 and read bits 7:3 return 0.
- R8: Writes aimed at the sample store, or at selector code 00, are acknowledged but issue no memory write. Reads with selector 00 return 0.
- R9: Once low, `ack_n` stays low while select and strobe stay active. It returns to 1 within 4 cycles after either one goes inactive.
- R10: `rdata_oe` is 1 only while `cs_n`=0, `ds`=1 and `rw`=1.
- R11: `msg_all` equals control bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host select, active low |
| ds | input | 1 | Host data strobe, active high |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 6 | Host address; bit 5 picks memory window versus control byte |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Host read data (zero when not driven) |
| rdata_oe | output | 1 | Read data drive enable |
| ack_n | output | 1 | Acknowledge, low = access done |
| msg_all | output | 1 | Global message flag to the switch core |
| slot_open | input | 1 | Host slot granted by the core schedule |
| mem_req | output | 1 | Memory request, one cycle |
| mem_we | output | 1 | 1 = write request |
| mem_sel | output | 2 | Target memory: 01 sample, 10 route, 11 flag |
| mem_addr | output | 8 | {stream, channel} |
| mem_wdata | output | 8 | Write data to the core |
| mem_rdata | input | 8 | Read data from the core, valid the cycle after the request |

## Verification
On every cycle, the assertions check the split-mode routing of requests, that no write request ever reaches the sample store, that each access issues a single request cycle, and that the acknowledge is held and released with the synchronized strobe. Other behaviours only show up in the bench's scenarios that look at data values: the control byte decoding under different low address bits, the masking of flag-store bytes, the silent discard of read-only writes, the exact address composition, and the bound on control-write latency.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
    localparam int DATA_W  = 8;
    localparam int CHAN_W  = 5;
    localparam int STRM_W  = 3;
    localparam int ADDR_W  = CHAN_W + 1;
    localparam int MADDR_W = STRM_W + CHAN_W;

    // control byte bit positions
    localparam int CB_SPLIT  = 7;
    localparam int CB_MSG    = 6;
    localparam int CB_UNUSED = 5;
    localparam int CB_SEL_HI = 4;
    localparam int CB_SEL_LO = 3;
    localparam int FLAG_W    = 3;

    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_SAMP = 2'b01,
        SEL_ROUTE = 2'b10,
        SEL_FLAG = 2'b11
    } mem_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CAPT,
        ST_ACK
    } seq_state_e;

    typedef struct packed {
        logic               is_ctrl;
        logic               do_mem;
        logic               is_flag;
        mem_sel_e           sel;
        logic [MADDR_W-1:0] maddr;
        logic [DATA_W-1:0]  wdata;
    } route_t;

    function automatic logic [DATA_W-1:0] flag_mask(input logic [DATA_W-1:0] v);
        logic [DATA_W-1:0] m;
        m = '0;
        m[FLAG_W-1:0] = v[FLAG_W-1:0];
        return m;
    endfunction
endpackage

// File: rtl/hpa_sync.sv
module hpa_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_single
            logic r;
            always_ff @(posedge clk) begin
                if (rst) r <= 1'b0;
                else     r <= d;
            end
            assign q = r;
        end else begin : g_chain
            logic [STAGES-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[STAGES-2:0], d};
            end
            assign q = sh[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/hpa_decode.sv
module hpa_decode
    import hpa_pkg::*;
(
    input  logic [DATA_W-1:0] ctrl,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              rw_q,
    input  logic [DATA_W-1:0] wd_q,
    output route_t            route
);
    mem_sel_e base_sel;

    always_comb begin
        base_sel = mem_sel_e'(ctrl[CB_SEL_HI:CB_SEL_LO]);
        route.is_ctrl = ~addr_q[ADDR_W-1];
        route.maddr   = {ctrl[STRM_W-1:0], addr_q[CHAN_W-1:0]};
        if (ctrl[CB_SPLIT]) begin
            route.sel = rw_q ? SEL_SAMP : SEL_ROUTE;
        end else begin
            route.sel = base_sel;
        end
        route.is_flag = (route.sel == SEL_FLAG);
        route.do_mem  = ~route.is_ctrl && (route.sel != SEL_NONE)
                        && !((route.sel == SEL_SAMP) && !rw_q);
        route.wdata   = route.is_flag ? flag_mask(wd_q) : wd_q;
    end
endmodule

// File: rtl/hpa_seq.sv
module hpa_seq
    import hpa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              act,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rw,
    input  logic [DATA_W-1:0] wdata,
    input  route_t            route,
    input  logic              slot_open,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic              rw_q,
    output logic [DATA_W-1:0] wd_q,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [DATA_W-1:0] rd_q,
    output logic              mem_req,
    output logic              mem_we,
    output logic              ack_n
);
    seq_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            rw_q   <= 1'b1;
            wd_q   <= '0;
            ctrl_q <= '0;
            rd_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (act) begin
                    addr_q <= addr;
                    rw_q   <= rw;
                    wd_q   <= wdata;
                    rd_q   <= '0;
                    if (!addr[ADDR_W-1] && !rw) begin
                        ctrl_q <= wdata & ~(DATA_W'(1) << CB_UNUSED);
                        state  <= ST_ACK;
                    end else begin
                        if (!addr[ADDR_W-1]) rd_q <= ctrl_q;
                        state <= ST_WAIT;
                    end
                end
                ST_WAIT: if (slot_open) state <= ST_CAPT;
                ST_CAPT: begin
                    if (route.do_mem && rw_q)
                        rd_q <= route.is_flag ? flag_mask(mem_rdata) : mem_rdata;
                    state <= ST_ACK;
                end
                ST_ACK: if (!act) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req = (state == ST_WAIT) && slot_open && route.do_mem;
    assign mem_we  = ~rw_q;
    assign ack_n   = (state != ST_ACK);

    p_one_req_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
    p_ack_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && act) |=> !ack_n);
    p_ack_drop_r9: assert property (@(posedge clk) disable iff (rst)
        (!ack_n && !act) |=> ack_n);
    p_ctrl_fast_r3: assert property (@(posedge clk) disable iff (rst)
        (ack_n && act && (state == ST_IDLE) && !addr[ADDR_W-1] && !rw) |=> !ack_n);
endmodule

// File: rtl/hpa_top.sv
module hpa_top
    import hpa_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ds,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              ack_n,
    output logic              msg_all,
    input  logic              slot_open,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_sel,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              act;
    logic [ADDR_W-1:0] addr_q;
    logic              rw_q;
    logic [DATA_W-1:0] wd_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rd_q;
    route_t            route;

    hpa_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .d(~cs_n & ds), .q(act)
    );

    hpa_decode i_decode (
        .ctrl(ctrl_q), .addr_q(addr_q), .rw_q(rw_q), .wd_q(wd_q), .route(route)
    );

    hpa_seq i_seq (
        .clk(clk), .rst(rst), .act(act), .addr(addr), .rw(rw), .wdata(wdata),
        .route(route), .slot_open(slot_open), .mem_rdata(mem_rdata),
        .addr_q(addr_q), .rw_q(rw_q), .wd_q(wd_q), .ctrl_q(ctrl_q), .rd_q(rd_q),
        .mem_req(mem_req), .mem_we(mem_we), .ack_n(ack_n)
    );

    assign mem_sel   = route.sel;
    assign mem_addr  = route.maddr;
    assign mem_wdata = route.wdata;
    assign msg_all   = ctrl_q[CB_MSG];
    assign rdata_oe  = ~cs_n & ds & rw;
    assign rdata     = rdata_oe ? rd_q : '0;

    p_split_rd_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && ctrl_q[CB_SPLIT]) |-> (mem_sel == SEL_SAMP));
    p_split_wr_r6: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && ctrl_q[CB_SPLIT]) |-> (mem_sel == SEL_ROUTE));
    p_no_samp_wr_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> (mem_sel != SEL_SAMP));
    p_flag_wr_mask_r7: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && (mem_sel == SEL_FLAG)) |-> (mem_wdata[DATA_W-1:FLAG_W] == '0));
endmodule

// File: tb/test_hpa_top.sv
module test_hpa_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, ds = 1'b0, rw = 1'b1;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic rdata_oe, ack_n, msg_all, slot_open, mem_req, mem_we;
    logic [1:0] mem_sel;
    logic [7:0] mem_addr, mem_wdata;
    logic [7:0] mem_rdata = '0;

    int n_chk = 0, n_bad = 0;
    int req_cnt = 0;
    logic [1:0] slot_cnt = '0;
    logic [7:0] samp [256];
    logic [7:0] route_m [256];
    logic [7:0] flag_m [256];

    always #2 clk = ~clk;

    hpa_top i_hpa_top (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ds(ds), .rw(rw), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .ack_n(ack_n),
        .msg_all(msg_all), .slot_open(slot_open), .mem_req(mem_req),
        .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // core model: one host slot every fourth cycle
    assign slot_open = (slot_cnt == 2'd3);
    always @(posedge clk) begin
        slot_cnt <= slot_cnt + 2'd1;
        if (mem_req) begin
            req_cnt <= req_cnt + 1;
            if (mem_we) begin
                case (mem_sel)
                    2'b01: samp[mem_addr] <= mem_wdata;
                    2'b10: route_m[mem_addr] <= mem_wdata;
                    2'b11: flag_m[mem_addr] <= mem_wdata;
                    default: ;
                endcase
            end
            case (mem_sel)
                2'b01: mem_rdata <= samp[mem_addr];
                2'b10: mem_rdata <= route_m[mem_addr];
                2'b11: mem_rdata <= flag_m[mem_addr];
                default: mem_rdata <= 8'h00;
            endcase
        end
    end

    task automatic chk(input logic ok, input string req, input int act_v, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    // R5: requests only inside the slot
    always @(negedge clk) begin
        if (!rst && mem_req && !slot_open) begin
            n_chk++; n_bad++;
            $display("FAIL R5 actual=req_outside_slot expected=slot_only");
        end
    end

    task automatic bus_access(input logic rd, input logic [5:0] a, input logic [7:0] d,
                              output logic [7:0] q, output int lat, output logic oe_seen);
        @(negedge clk);
        cs_n = 1'b0; ds = 1'b1; rw = rd; addr = a; wdata = d;
        lat = 0;
        while (ack_n && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        q = rdata;
        oe_seen = rdata_oe;
        cs_n = 1'b1; ds = 1'b0;
        begin
            int rel = 0;
            while (!ack_n && rel < 10) begin
                @(negedge clk);
                rel++;
            end
            chk(ack_n && rel <= 4, "R9", rel, 4);
        end
        rw = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d, output int lat);
        logic [7:0] q; logic oe;
        bus_access(1'b0, a, d, q, lat, oe);
        chk(!oe, "R10", oe, 0);
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] q);
        int lat; logic oe;
        bus_access(1'b1, a, 8'h00, q, lat, oe);
        chk(oe, "R10", oe, 1);
    endtask

    task automatic t_reset();
        logic [7:0] q;
        chk(ack_n === 1'b1, "R1", ack_n, 1);
        chk(rdata_oe === 1'b0, "R1", rdata_oe, 0);
        chk(msg_all === 1'b0 && mem_req === 1'b0, "R1", msg_all, 0);
        rd(6'h00, q);
        chk(q == 8'h00, "R1", q, 0);
    endtask

    task automatic t_ctrl();
        logic [7:0] q; int lat, r0;
        r0 = req_cnt;
        wr(6'h1F, 8'hE5, lat);
        chk(lat <= 4, "R3", lat, 4);
        chk(req_cnt == r0, "R3", req_cnt - r0, 0);
        rd(6'h0A, q);
        chk(q == 8'hC5, "R2", q, 8'hC5);
        chk(msg_all == 1'b1, "R11", msg_all, 1);
        wr(6'h00, 8'h00, lat);
        chk(msg_all == 1'b0, "R11", msg_all, 0);
    endtask

    task automatic t_route();
        logic [7:0] q; int lat, r0;
        wr(6'h00, 8'h13, lat);          // route store, stream 3
        r0 = req_cnt;
        wr(6'h29, 8'hA7, lat);          // channel 9
        chk(route_m[8'd105] == 8'hA7, "R4", route_m[8'd105], 8'hA7);
        chk(req_cnt - r0 == 1, "R5", req_cnt - r0, 1);
        rd(6'h29, q);
        chk(q == 8'hA7, "R4", q, 8'hA7);
    endtask

    task automatic t_flag();
        logic [7:0] q; int lat;
        wr(6'h00, 8'h1A, lat);          // flag store, stream 2
        wr(6'h24, 8'hFF, lat);
        chk(flag_m[8'd68] == 8'h07, "R7", flag_m[8'd68], 7);
        flag_m[8'd69] = 8'hF5;
        rd(6'h25, q);
        chk(q == 8'h05, "R7", q, 5);
    endtask

    task automatic t_samp();
        logic [7:0] q; int lat, r0;
        samp[8'd191] = 8'h3C;
        wr(6'h00, 8'h0D, lat);          // sample store, stream 5
        rd(6'h3F, q);
        chk(q == 8'h3C, "R4", q, 8'h3C);
        r0 = req_cnt;
        wr(6'h3F, 8'h99, lat);
        chk(req_cnt == r0 && samp[8'd191] == 8'h3C, "R8", samp[8'd191], 8'h3C);
        wr(6'h00, 8'h05, lat);          // selector 00
        r0 = req_cnt;
        wr(6'h20, 8'h77, lat);
        chk(req_cnt == r0 && ack_n, "R8", req_cnt - r0, 0);
        rd(6'h20, q);
        chk(q == 8'h00, "R8", q, 0);
    endtask

    task automatic t_split();
        logic [7:0] q; int lat;
        samp[8'd71] = 8'h5A;
        flag_m[8'd71] = 8'h02;
        wr(6'h00, 8'h9A, lat);          // split, flag selector, stream 2
        rd(6'h27, q);
        chk(q == 8'h5A, "R6", q, 8'h5A);
        wr(6'h27, 8'h66, lat);
        chk(route_m[8'd71] == 8'h66, "R6", route_m[8'd71], 8'h66);
        chk(flag_m[8'd71] == 8'h02, "R6", flag_m[8'd71], 2);
        wr(6'h00, 8'h1A, lat);
        rd(6'h27, q);
        chk(q == 8'h02, "R6", q, 2);
    endtask

    task automatic t_oe();
        @(negedge clk);
        cs_n = 1'b0; ds = 1'b0; rw = 1'b1;
        #1 chk(rdata_oe == 1'b0, "R10", rdata_oe, 0);
        cs_n = 1'b1; ds = 1'b1;
        #1 chk(rdata_oe == 1'b0, "R10", rdata_oe, 0);
        repeat (4) @(negedge clk);
        chk(ack_n == 1'b1, "R10", ack_n, 1);
        ds = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_hold();
        int lat = 0;
        @(negedge clk);
        cs_n = 1'b0; ds = 1'b1; rw = 1'b0; addr = 6'h00; wdata = 8'h00;
        while (ack_n && lat < 20) begin @(negedge clk); lat++; end
        repeat (10) @(negedge clk);
        chk(ack_n == 1'b0, "R9", ack_n, 0);
        ds = 1'b0; cs_n = 1'b1; rw = 1'b1;
        repeat (4) @(negedge clk);
        chk(ack_n == 1'b1, "R9", ack_n, 1);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            samp[i] = 8'h00; route_m[i] = 8'h00; flag_m[i] = 8'h00;
        end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_route();
        t_flag();
        t_samp();
        t_split();
        t_oe();
        t_hold();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule